// File: doc/BRIEF.md
# I2C Master Clock Synchroniser with Stretch and Wait Hold

This block produces the SCL clock for the master side of an I2C byte transfer. A down-counter loaded from a baud value sets the length of each clock phase. The block keeps its internal clock in step with the level it reads back from the open-drain SCL line, so any other device that pulls the line low shortens the high phase or stretches the low phase, and the block follows.

The clock that the shifter actually sees is the AND of the internal SCL and the synchronised pin level. The block gives the shifter a one-cycle strobe on each rising and each falling edge of that clock, and it flags the ninth (acknowledge) bit.

Synchronisation runs from the start of the transfer up to the ninth rising edge. After the ninth falling edge the block can keep SCL low until software clears the wait enable.

A pulse on `start_i` while idle begins a transfer of nine clocks. The pin level passes through a two-flop synchroniser before the block uses it.

Top module: `i2c_scl_sync`

## Requirements
- R1: A `start_i` pulse while idle begins a transfer. In the cycle after the start edge, `scl_drive_low_o` is 1, where 1 means the line is pulled low.
- R2: With synchronisation on and no other device on the line, each effective high phase lasts baud+1 cycles and the rise-to-rise period is 2*baud+6 cycles. The extra cycles come from waiting for the synchronised pin to follow each internal edge.
- R3: With synchronisation on, a falling edge on the pin while the internal SCL is high forces the internal SCL low and reloads the counter. `scl_drive_low_o` rises within 4 cycles of the external pull.
- R4: With synchronisation on, when another device holds SCL low across an internal rise, the counter stops. After the line is released, the effective high phase still lasts baud+1 cycles.
- R5: With synchronisation off, the internal clock free-runs with phases of baud+1 cycles. The effective high phase is then baud-1 cycles, with a period of 2*baud+2, and it gets shorter when another device holds the line.
- R6: One transfer gives exactly nine rise strobes and nine fall strobes. `ninth_o` is 0 at the eighth fall strobe and 1 at the ninth.
- R7: After the ninth rise, synchronisation is off. A pin fall during the ninth high phase does not force the internal SCL low.
- R8: If `wait_en_i` is 1 at the end of a transfer, SCL stays pulled low after the ninth fall. Clearing `wait_en_i` releases it within 2 cycles. With `wait_en_i` at 0, the line is released after the transfer.
- R9: In reset and while idle, `scl_drive_low_o`, `rise_stb_o`, `fall_stb_o` and `ninth_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pin_i | input | 1 | Level read back from the SCL line |
| sync_en_i | input | 1 | Enables wired-AND clock synchronisation |
| wait_en_i | input | 1 | Holds SCL low after the ninth fall |
| baud_i | input | CNT_W | Counter reload value for each phase |
| start_i | input | 1 | Begins a nine-clock transfer when idle |
| scl_drive_low_o | output | 1 | 1 pulls the SCL line low |
| rise_stb_o | output | 1 | One-cycle strobe on each effective SCL rise |
| fall_stb_o | output | 1 | One-cycle strobe on each effective SCL fall |
| ninth_o | output | 1 | High from the ninth rise through the ninth fall |

## Verification
The bench measures effective high times and periods across several baud values, with synchronisation both on and off. A design that miscounted the synchroniser latency, or that froze the counter with synchronisation off, would give wrong lengths.

It then runs three directed tests. In the first, another device stretches the clock across a rise; a design that did not freeze the counter would show a short high phase. In the second, another device pulls SCL low mid-high; a design that ignored the pin would keep driving high. In the third, the pin is pulsed during the ninth high phase; a design that kept synchronising there would cut the acknowledge clock short.

The wait hold is checked both for staying low and for releasing when the enable is cleared.

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
  parameter int CNT_W = 8,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_pin_i,
  input  logic             sync_en_i,
  input  logic             wait_en_i,
  input  logic [CNT_W-1:0] baud_i,
  input  logic             start_i,
  output logic             scl_drive_low_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o,
  output logic             ninth_o
);
  localparam int RW = $clog2(NBITS + 2);
  localparam logic [RW-1:0] LAST = RW'(NBITS);
  localparam logic [RW-1:0] DONE = RW'(NBITS + 1);

  logic             p1, p2, pin_q;
  logic             run, int_scl, eff_q, hold;
  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1    <= 1'b1;
      p2    <= 1'b1;
      pin_q <= 1'b1;
    end else begin
      p1    <= scl_pin_i;
      p2    <= p1;
      pin_q <= p2;
    end
  end

  logic          win, pin_fall, eff, sync_on, force_low, freeze;
  logic [RW-1:0] rises_inc;

  assign win        = rises < LAST;
  assign pin_fall   = pin_q & ~p2;
  assign eff        = run ? (int_scl & p2) : 1'b1;
  assign rise_stb_o = run & eff & ~eff_q;
  assign fall_stb_o = run & ~eff & eff_q;
  assign rises_inc  = (rise_stb_o && win) ? rises + 1'b1 : rises;
  assign sync_on    = run & sync_en_i & win;
  assign force_low  = sync_on & int_scl & pin_fall;
  assign freeze     = sync_on & (int_scl ? ~p2 : p2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      int_scl <= 1'b1;
      cnt     <= '0;
      rises   <= '0;
      eff_q   <= 1'b1;
      hold    <= 1'b0;
    end else if (!run) begin
      eff_q <= 1'b1;
      hold  <= hold & wait_en_i;
      if (start_i) begin
        run     <= 1'b1;
        int_scl <= 1'b0;
        cnt     <= baud_i;
        rises   <= '0;
        eff_q   <= 1'b0;
        hold    <= 1'b0;
      end
    end else begin
      eff_q <= eff;
      rises <= rises_inc;
      if (rises == DONE) begin
        run     <= 1'b0;
        int_scl <= 1'b1;
        hold    <= wait_en_i;
      end else if (force_low) begin
        int_scl <= 1'b0;
        cnt     <= baud_i;
      end else if (!freeze) begin
        if (cnt == '0) begin
          int_scl <= ~int_scl;
          cnt     <= baud_i;
          if (int_scl && rises_inc == LAST) rises <= DONE;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign scl_drive_low_o = hold | (run & ~int_scl);
  assign ninth_o         = run & (rises >= LAST);

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !run |=> scl_drive_low_o);

  // R3
  sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && sync_en_i && win && int_scl && pin_fall |=> !int_scl && cnt == $past(baud_i));

  // R4
  freeze_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && sync_en_i && win && int_scl && !p2 && !pin_fall |=> int_scl && $stable(cnt));

  // R2
  freeze_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && sync_en_i && win && !int_scl && p2 |=> !int_scl && $stable(cnt));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && wait_en_i |=> scl_drive_low_o);

  // R8
  hold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(rises) == DONE);
endmodule

// File: tb/test_i2c_scl_sync.sv
`timescale 1ns/1ps
module test_i2c_scl_sync;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_en = 1'b1, wait_en = 1'b0, start = 1'b0, ext_low = 1'b0;
  logic [7:0] baud = 8'd3;
  logic drv, rstb, fstb, nin;
  logic scl_pin;
  assign scl_pin = ~(drv | ext_low);

  always #4 clk = ~clk;

  i2c_scl_sync i_i2c_scl_sync (
    .clk(clk), .rst_n(rst_n), .scl_pin_i(scl_pin), .sync_en_i(sync_en),
    .wait_en_i(wait_en), .baud_i(baud), .start_i(start),
    .scl_drive_low_o(drv), .rise_stb_o(rstb), .fall_stb_o(fstb), .ninth_o(nin));

  int n_chk = 0, n_err = 0;
  int cyc = 0, nrise = 0, nfall = 0;
  int t_r1 = 0, t_r2 = 0, t_f1 = 0, t_rise = 0, last_high = 0;
  logic nin8 = 1'b0, nin9 = 1'b0, mon_clr = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      nrise = 0; nfall = 0;
    end else begin
      if (rstb) begin
        nrise++;
        if (nrise == 1) t_r1 = cyc;
        if (nrise == 2) t_r2 = cyc;
        t_rise = cyc;
      end
      if (fstb) begin
        nfall++;
        if (nfall == 1) t_f1 = cyc;
        last_high = cyc - t_rise;
        if (nfall == 8) nin8 = nin;
        if (nfall == 9) nin9 = nin;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic kick();
    mon_clr = 1'b1; start = 1'b1;
    step();
    start = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_falls(input int n);
    int g = 0;
    while (nfall < n && g < 3000) begin step(); g++; end
    if (g >= 3000) chk(1'b0, "watchdog", nfall, n);
  endtask

  localparam int VEC [6][4] = '{
    '{0, 1, 1, 6}, '{3, 1, 4, 12}, '{7, 1, 8, 20},
    '{12, 1, 13, 30}, '{4, 0, 3, 10}, '{9, 0, 8, 20}};

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    step(3);
    chk(drv == 0 && rstb == 0 && fstb == 0 && nin == 0, "R9 in reset", drv, 0);
    rst_n = 1'b1;
    step(5);
    chk(drv == 0 && rstb == 0 && fstb == 0 && nin == 0, "R9 idle", drv, 0);

    for (int v = 0; v < 6; v++) begin
      baud = 8'(VEC[v][0]); sync_en = VEC[v][1][0]; wait_en = 1'b0;
      kick();
      chk(drv == 1, "R1 start pulls low", drv, 1);
      wait_falls(9);
      step(4 * VEC[v][0] + 20);
      chk(t_f1 - t_r1 == VEC[v][2], sync_en ? "R2 high phase" : "R5 high phase", t_f1 - t_r1, VEC[v][2]);
      chk(t_r2 - t_r1 == VEC[v][3], sync_en ? "R2 period" : "R5 period", t_r2 - t_r1, VEC[v][3]);
      chk(nrise == 9, "R6 rise count", nrise, 9);
      chk(nfall == 9, "R6 fall count", nfall, 9);
      chk(nin8 == 0 && nin9 == 1, "R6 ninth flag", {nin8, nin9}, 1);
      chk(drv == 0, "R8 released without wait", drv, 0);
    end

    // R4: stretch across a rise with sync on
    baud = 8'd10; sync_en = 1'b1;
    kick();
    wait_falls(2);
    ext_low = 1'b1;
    while (drv == 1) step();
    step(6);
    ext_low = 1'b0;
    wait_falls(3);
    chk(last_high == 11, "R4 stretched high", last_high, 11);
    wait_falls(9); step(80);

    // R5: same stretch with sync off
    sync_en = 1'b0;
    kick();
    wait_falls(2);
    ext_low = 1'b1;
    while (drv == 1) step();
    step(6);
    ext_low = 1'b0;
    wait_falls(3);
    chk(last_high < 11 && last_high > 0, "R5 no freeze", last_high, 11);
    wait_falls(9); step(80);

    // R3: external pull during high phase
    baud = 8'd20; sync_en = 1'b1;
    kick();
    while (nrise < 3) step();
    step(3);
    ext_low = 1'b1;
    step(4);
    chk(drv == 1, "R3 forced low", drv, 1);
    ext_low = 1'b0;
    wait_falls(9); step(120);

    // R7: pin pulse during ninth high phase
    kick();
    while (nrise < 9) step();
    step(2);
    chk(nin == 1, "R6 ninth high", nin, 1);
    ext_low = 1'b1;
    step(2);
    ext_low = 1'b0;
    step(2);
    chk(drv == 0, "R7 no sync after ninth rise", drv, 0);
    step(120);

    // R8: wait hold
    baud = 8'd3; wait_en = 1'b1;
    kick();
    wait_falls(9);
    step(20);
    chk(drv == 1, "R8 held low", drv, 1);
    step(30);
    chk(drv == 1, "R8 still held", drv, 1);
    wait_en = 1'b0;
    step(2);
    chk(drv == 0, "R8 released", drv, 0);
    step(5);
    chk(rstb == 0 && fstb == 0 && nin == 0, "R9 idle after hold", nin, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule